// File: doc/BRIEF.md
# Byte-Wide Battery RAM with BCD Calendar Clock

This block is a byte-addressed store that a processor reaches through a plain synchronous bus with address, write data, write strobe, read strobe and read data. Most of the address space is ordinary RAM. The top eight byte addresses form a calendar clock window instead. The window holds a control byte and the seconds, minutes, hours, weekday with century flag, date, month and year fields. Software reads and writes these fields in packed BCD.

A single-cycle pulse on the tick input advances the calendar by one second. Carries ripple through the fields up to the year, using month lengths and a leap rule in which every fourth year is a leap year.

The address width is a parameter. A value of 11 gives a 2 KB device and a value of 13 gives an 8 KB device; no other value elaborates. The clock window always occupies the last eight addresses. Writes to a time field are screened: a field takes the new value only if that value is valid BCD and lies inside the field's range. The stop flag, the century flag and the control byte are stored apart from the counting fields.

Top module: `tk_nvram_clock`

## Requirements
- R1: Addresses below 2**ADDR_W-8 form a plain RAM. A byte written there reads back unchanged, and a write to one address leaves every other address unchanged.
- R2: The last eight addresses are the clock window. Offsets 0 to 7 (address bits 2:0) select, in order: control, seconds, minutes, hours, weekday/century, date, month and year. Read data appears one clock after the read strobe and holds until the next read.
- R3: A control write stores (data AND 0x5F) OR 0x90, so bits 7 and 4 always read as 1 and bit 5 always reads as 0. The control byte resets to 0x90.
- R4: Bit 7 of a seconds write sets or clears the stop flag whether or not the seconds value is accepted. While the stop flag is set, ticks leave every time field unchanged. Clearing the flag lets counting resume.
- R5: A seconds write is accepted only if bits 6:0, read as BCD, give a value from 0 to 59. A seconds read returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R6: A minutes write uses bits 6:0 and is accepted only for values 0 to 59. An hours write uses bits 5:0 and is accepted only for values 0 to 23. A rejected write leaves the field unchanged.
- R7: A weekday/century write always stores the weekday from bits 2:0 and the century flag from bit 6. A read returns the century flag in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R8: A date write uses bits 5:0 and is accepted only for 1 to 31. A month write uses bits 4:0 and is accepted only for 1 to 12. A year write uses all 8 bits and is accepted only for 0 to 99. Any BCD digit above 9 rejects the whole write.
- R9: After reset the fields read as: seconds 0, minutes 0, hours 0, weekday 1, date 1, month 1, year 0. The stop flag and the century flag are clear, and the read data is 0x00.
- R10: A tick with the stop flag clear adds one second. Seconds roll from 59 into minutes, minutes from 59 into hours, and hours from 23 into the day. At a day carry the weekday goes from 7 to 1 and otherwise increments.
- R11: At a day carry, a date at or beyond the month's length returns to 1 and advances the month. February has 29 days when the year is divisible by 4 and 28 otherwise; April, June, September and November have 30; the other months have 31. Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R12: A tick that arrives in the same cycle as a write into the clock window is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| tick_1hz | input | 1 | One-cycle pulse that adds one second |
| rdata | output | 8 | Registered read data |

## Verification
A corrupted time field shows up on the very next read of that field, one clock after the read strobe. If the carry logic is wrong, the error stays hidden until a tick crosses the faulty boundary; after that, every read of the higher fields returns a wrong BCD value for good. A stop flag that is lost, or that sticks, is revealed by the first tick that follows: the seconds field then advances when it should not, or fails to advance when it should. A write-screening fault leaves an out-of-range or non-BCD value in a field, and the read immediately after the write exposes it.

// File: rtl/tk_pkg.sv
package tk_pkg;

   typedef enum logic [2:0] {
      TK_CTRL  = 3'd0,
      TK_SEC   = 3'd1,
      TK_MIN   = 3'd2,
      TK_HOUR  = 3'd3,
      TK_DAY   = 3'd4,
      TK_DATE  = 3'd5,
      TK_MONTH = 3'd6,
      TK_YEAR  = 3'd7
   } tk_reg_e;

   localparam logic [7:0] CTRL_KEEP  = 8'h5F;
   localparam logic [7:0] CTRL_FORCE = 8'h90;

   // both digits must be decimal
   function automatic logic bcd_ok(input logic [7:0] v);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
   endfunction

   function automatic logic [6:0] bcd2bin(input logic [7:0] v);
      return 7'(7'(v[7:4]) * 7'd10) + 7'(v[3:0]);
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [6:0] b);
      return {4'(b / 7'd10), 4'(b % 7'd10)};
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
      case (mon)
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         4'd2:                   return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
         default:                return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/tk_decode.sv
module tk_decode #(
   parameter int ADDR_W = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_window,
   output tk_pkg::tk_reg_e   reg_sel
);
   always_comb begin
      in_window = &addr[ADDR_W-1:3];
      reg_sel   = tk_pkg::tk_reg_e'(addr[2:0]);
   end
endmodule

// File: rtl/tk_ram.sv
module tk_ram #(
   parameter int ADDR_W = 11,
   parameter int DEPTH  = 2040
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(addr) < DEPTH)) mem[addr] <= din;
   end

   always_comb dout = (int'(addr) < DEPTH) ? mem[addr] : 8'h00;
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
   import tk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  tk_reg_e    sel,
   input  logic [7:0] wdata,
   input  logic       tick,
   output logic [7:0] rd_val,
   output logic [5:0] sec_o,
   output logic [5:0] min_o,
   output logic [4:0] hour_o,
   output logic [4:0] date_o,
   output logic [3:0] mon_o,
   output logic [6:0] year_o,
   output logic       stop_o
);
   logic [7:0] ctrl_q;
   logic       stop_q, cent_q;
   logic [5:0] sec_q, min_q;
   logic [4:0] hour_q, date_q;
   logic [2:0] wday_q;
   logic [3:0] mon_q;
   logic [6:0] year_q;

   logic [5:0] n_sec, n_min;
   logic [4:0] n_hour, n_date;
   logic [2:0] n_wday;
   logic [3:0] n_mon;
   logic [6:0] n_year;

   // screened field values
   logic [7:0] w_sec, w_min, w_hour, w_date, w_mon;
   logic [6:0] b_sec, b_min, b_hour, b_date, b_mon, b_year;
   logic       ok_sec, ok_min, ok_hour, ok_date, ok_mon, ok_year;

   always_comb begin
      w_sec  = {1'b0, wdata[6:0]};
      w_min  = {1'b0, wdata[6:0]};
      w_hour = {2'b0, wdata[5:0]};
      w_date = {2'b0, wdata[5:0]};
      w_mon  = {3'b0, wdata[4:0]};
      b_sec  = bcd2bin(w_sec);
      b_min  = bcd2bin(w_min);
      b_hour = bcd2bin(w_hour);
      b_date = bcd2bin(w_date);
      b_mon  = bcd2bin(w_mon);
      b_year = bcd2bin(wdata);
      ok_sec  = bcd_ok(w_sec)  && (b_sec  <= 7'd59);
      ok_min  = bcd_ok(w_min)  && (b_min  <= 7'd59);
      ok_hour = bcd_ok(w_hour) && (b_hour <= 7'd23);
      ok_date = bcd_ok(w_date) && (b_date >= 7'd1) && (b_date <= 7'd31);
      ok_mon  = bcd_ok(w_mon)  && (b_mon  >= 7'd1) && (b_mon  <= 7'd12);
      ok_year = bcd_ok(wdata)  && (b_year <= 7'd99);
   end

   // one-second carry chain
   always_comb begin
      n_sec  = sec_q;
      n_min  = min_q;
      n_hour = hour_q;
      n_wday = wday_q;
      n_date = date_q;
      n_mon  = mon_q;
      n_year = year_q;
      if (sec_q < 6'd59) begin
         n_sec = sec_q + 6'd1;
      end else begin
         n_sec = 6'd0;
         if (min_q < 6'd59) begin
            n_min = min_q + 6'd1;
         end else begin
            n_min = 6'd0;
            if (hour_q < 5'd23) begin
               n_hour = hour_q + 5'd1;
            end else begin
               n_hour = 5'd0;
               n_wday = (wday_q >= 3'd7) ? 3'd1 : wday_q + 3'd1;
               if (date_q < month_len(mon_q, year_q)) begin
                  n_date = date_q + 5'd1;
               end else begin
                  n_date = 5'd1;
                  if (mon_q < 4'd12) begin
                     n_mon = mon_q + 4'd1;
                  end else begin
                     n_mon  = 4'd1;
                     n_year = (year_q >= 7'd99) ? 7'd0 : year_q + 7'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_FORCE;
         stop_q <= 1'b0;
         cent_q <= 1'b0;
         sec_q  <= '0;
         min_q  <= '0;
         hour_q <= '0;
         wday_q <= 3'd1;
         date_q <= 5'd1;
         mon_q  <= 4'd1;
         year_q <= '0;
      end else if (wr_stb) begin
         case (sel)
            TK_CTRL:  ctrl_q <= (wdata & CTRL_KEEP) | CTRL_FORCE;
            TK_SEC: begin
               stop_q <= wdata[7];
               if (ok_sec) sec_q <= b_sec[5:0];
            end
            TK_MIN:   if (ok_min)  min_q  <= b_min[5:0];
            TK_HOUR:  if (ok_hour) hour_q <= b_hour[4:0];
            TK_DAY: begin
               wday_q <= wdata[2:0];
               cent_q <= wdata[6];
            end
            TK_DATE:  if (ok_date) date_q <= b_date[4:0];
            TK_MONTH: if (ok_mon)  mon_q  <= b_mon[3:0];
            default:  if (ok_year) year_q <= b_year;
         endcase
      end else if (tick && !stop_q) begin
         sec_q  <= n_sec;
         min_q  <= n_min;
         hour_q <= n_hour;
         wday_q <= n_wday;
         date_q <= n_date;
         mon_q  <= n_mon;
         year_q <= n_year;
      end
   end

   logic [7:0] e_sec, e_min, e_hour, e_date, e_mon, e_year;
   always_comb begin
      e_sec  = bin2bcd({1'b0, sec_q});
      e_min  = bin2bcd({1'b0, min_q});
      e_hour = bin2bcd({2'b0, hour_q});
      e_date = bin2bcd({2'b0, date_q});
      e_mon  = bin2bcd({3'b0, mon_q});
      e_year = bin2bcd(year_q);
      case (sel)
         TK_CTRL:  rd_val = ctrl_q;
         TK_SEC:   rd_val = {stop_q, e_sec[6:0]};
         TK_MIN:   rd_val = {1'b0, e_min[6:0]};
         TK_HOUR:  rd_val = {2'b0, e_hour[5:0]};
         TK_DAY:   rd_val = {1'b0, cent_q, 3'b000, wday_q};
         TK_DATE:  rd_val = {2'b0, e_date[5:0]};
         TK_MONTH: rd_val = {3'b0, e_mon[4:0]};
         default:  rd_val = e_year;
      endcase
      sec_o  = sec_q;
      min_o  = min_q;
      hour_o = hour_q;
      date_o = date_q;
      mon_o  = mon_q;
      year_o = year_q;
      stop_o = stop_q;
   end
endmodule

// File: rtl/tk_nvram_clock.sv
module tk_nvram_clock #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              tick_1hz,
   output logic [7:0]        rdata
);
   localparam int WIN_REGS  = 8;
   localparam int RAM_DEPTH = (1 << ADDR_W) - WIN_REGS;

   generate
      if (ADDR_W != 11 && ADDR_W != 13) begin : g_bad_width
         $error("tk_nvram_clock: ADDR_W must be 11 (2 KB) or 13 (8 KB)");
      end
   endgenerate

   logic            in_win;
   tk_pkg::tk_reg_e sel;
   logic [7:0]      ram_rd, cal_rd, rdata_q;
   logic [5:0]      sec_w, min_w;
   logic [4:0]      hour_w, date_w;
   logic [3:0]      mon_w;
   logic [6:0]      year_w;
   logic            stop_w;

   tk_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(addr), .in_window(in_win), .reg_sel(sel)
   );

   tk_ram #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH)) u_ram (
      .clk(clk), .we(wr_en && !in_win), .addr(addr), .din(wdata), .dout(ram_rd)
   );

   tk_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_en && in_win), .sel(sel),
      .wdata(wdata), .tick(tick_1hz), .rd_val(cal_rd),
      .sec_o(sec_w), .min_o(min_w), .hour_o(hour_w), .date_o(date_w),
      .mon_o(mon_w), .year_o(year_w), .stop_o(stop_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata_q <= 8'h00;
      else if (rd_en) rdata_q <= in_win ? cal_rd : ram_rd;
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/tk_nvram_clock_chk.sv
module tk_nvram_clock_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic              wr_en,
   input logic              rd_en,
   input logic              tick_1hz,
   input logic [7:0]        rdata,
   input logic [5:0]        sec_w,
   input logic [5:0]        min_w,
   input logic [4:0]        date_w,
   input logic              stop_w
);
   logic win, min_ok;
   always_comb begin
      win    = &addr[ADDR_W-1:3];
      min_ok = tk_pkg::bcd_ok({1'b0, wdata[6:0]}) &&
               (tk_pkg::bcd2bin({1'b0, wdata[6:0]}) <= 7'd59);
   end

   AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_w <= 6'd59); // R5

   AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (date_w >= 5'd1) && (date_w <= 5'd31)); // R8

   AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && win && addr[2:0] == 3'd0) |=> (rdata[7] && rdata[4] && !rdata[5])); // R3

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_w && !(wr_en && win)) |=> $stable(sec_w) && $stable(min_w)); // R4

   AST_MIN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && win && addr[2:0] == 3'd2 && !min_ok) |=> $stable(min_w)); // R6

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !stop_w && !(wr_en && win) && sec_w < 6'd59)
      |=> (sec_w == $past(sec_w) + 6'd1)); // R10

   AST_TICK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && wr_en && win && addr[2:0] != 3'd1) |=> $stable(sec_w)); // R12
endmodule

bind tk_nvram_clock tk_nvram_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
   .rd_en(rd_en), .tick_1hz(tick_1hz), .rdata(rdata), .sec_w(sec_w),
   .min_w(min_w), .date_w(date_w), .stop_w(stop_w)
);

// File: tb/tk_nvram_clock_tb.sv
module tk_nvram_clock_tb;
   localparam int AW   = 11;
   localparam int BASE = (1 << AW) - 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0, tick_1hz = 1'b0;
   logic [7:0]    rdata;

   int checks = 0, errors = 0;

   // reference state
   int s_ctrl, s_stop, s_cent, s_sec, s_min, s_hour, s_wday, s_date, s_mon, s_year;
   logic [7:0] ram_m [BASE];
   bit         ram_v [BASE];

   always #4 clk = ~clk;

   tk_nvram_clock #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .tick_1hz(tick_1hz), .rdata(rdata)
   );

   function automatic int dec(input logic [7:0] v);
      if (v[7:4] > 4'd9 || v[3:0] > 4'd9) return -1;
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] enc(input int b);
      return 8'(((b / 10) << 4) + (b % 10));
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      return 31;
   endfunction

   function automatic void m_reset();
      s_ctrl = 8'h90; s_stop = 0; s_cent = 0; s_sec = 0; s_min = 0; s_hour = 0;
      s_wday = 1; s_date = 1; s_mon = 1; s_year = 0;
   endfunction

   function automatic void m_write(input int r, input logic [7:0] d);
      int v;
      case (r)
         0: s_ctrl = int'((d & 8'h5F) | 8'h90);
         1: begin s_stop = int'(d[7]); v = dec({1'b0, d[6:0]}); if (v >= 0 && v <= 59) s_sec = v; end
         2: begin v = dec({1'b0, d[6:0]}); if (v >= 0 && v <= 59) s_min = v; end
         3: begin v = dec({2'b0, d[5:0]}); if (v >= 0 && v <= 23) s_hour = v; end
         4: begin s_wday = int'(d[2:0]); s_cent = int'(d[6]); end
         5: begin v = dec({2'b0, d[5:0]}); if (v >= 1 && v <= 31) s_date = v; end
         6: begin v = dec({3'b0, d[4:0]}); if (v >= 1 && v <= 12) s_mon = v; end
         default: begin v = dec(d); if (v >= 0 && v <= 99) s_year = v; end
      endcase
   endfunction

   function automatic void m_tick();
      if (s_stop != 0) return;
      if (s_sec < 59) begin s_sec++; return; end
      s_sec = 0;
      if (s_min < 59) begin s_min++; return; end
      s_min = 0;
      if (s_hour < 23) begin s_hour++; return; end
      s_hour = 0;
      s_wday = (s_wday >= 7) ? 1 : s_wday + 1;
      if (s_date < mlen(s_mon, s_year)) begin s_date++; return; end
      s_date = 1;
      if (s_mon < 12) begin s_mon++; return; end
      s_mon = 1;
      s_year = (s_year >= 99) ? 0 : s_year + 1;
   endfunction

   function automatic logic [7:0] m_read(input int r);
      case (r)
         0: return 8'(s_ctrl);
         1: return enc(s_sec) | (s_stop != 0 ? 8'h80 : 8'h00);
         2: return enc(s_min);
         3: return enc(s_hour);
         4: return 8'((s_cent << 6) | s_wday);
         5: return enc(s_date);
         6: return enc(s_mon);
         default: return enc(s_year);
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d, input bit with_tick = 0);
      @(negedge clk);
      addr = AW'(a); wdata = d; wr_en = 1'b1; tick_1hz = with_tick;
      @(negedge clk);
      wr_en = 1'b0; tick_1hz = 1'b0;
      if (a >= BASE) m_write(a - BASE, d);
      else begin ram_m[a] = d; ram_v[a] = 1'b1; end
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1hz = 1'b1;
         @(negedge clk); tick_1hz = 1'b0;
         m_tick();
      end
   endtask

   task automatic rd_chk(input int a, input string tag);
      logic [7:0] exp;
      @(negedge clk);
      addr = AW'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      exp = (a >= BASE) ? m_read(a - BASE) : ram_m[a];
      chk(tag, rdata, exp, $sformatf("read addr 0x%03h", a));
   endtask

   task automatic set_time(input int yr, input int mo, input int dt, input int hr, input int mi, input int se);
      wr(BASE + 7, enc(yr)); wr(BASE + 6, enc(mo)); wr(BASE + 5, enc(dt));
      wr(BASE + 3, enc(hr)); wr(BASE + 2, enc(mi)); wr(BASE + 1, enc(se));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240517));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      @(negedge clk);
      chk("R9", rdata, 8'h00, "rdata after reset");
      for (int r = 0; r < 8; r++) rd_chk(BASE + r, "R9");

      // R1 RAM at both ends, R2 window reads
      wr(0, 8'hA5); wr(BASE - 1, 8'h3C); wr(100, 8'h00);
      rd_chk(0, "R1"); rd_chk(BASE - 1, "R1"); rd_chk(100, "R1");

      // R3 control forcing
      wr(BASE, 8'h25);  rd_chk(BASE, "R3");
      wr(BASE, 8'hFF);  rd_chk(BASE, "R3");
      chk("R3", rdata, 8'hDF, "control after 0xFF");

      // R5/R6/R8 screening
      wr(BASE + 1, 8'h5A); rd_chk(BASE + 1, "R5");
      wr(BASE + 1, 8'h60); rd_chk(BASE + 1, "R5");
      wr(BASE + 2, 8'h59); rd_chk(BASE + 2, "R6");
      wr(BASE + 2, 8'h60); rd_chk(BASE + 2, "R6");
      wr(BASE + 3, 8'h24); rd_chk(BASE + 3, "R6");
      wr(BASE + 3, 8'h23); rd_chk(BASE + 3, "R6");
      wr(BASE + 5, 8'h00); rd_chk(BASE + 5, "R8");
      wr(BASE + 5, 8'h31); rd_chk(BASE + 5, "R8");
      wr(BASE + 5, 8'h32); rd_chk(BASE + 5, "R8");
      wr(BASE + 6, 8'h13); rd_chk(BASE + 6, "R8");
      wr(BASE + 6, 8'h0C); rd_chk(BASE + 6, "R8");
      wr(BASE + 7, 8'h9A); rd_chk(BASE + 7, "R8");
      wr(BASE + 7, 8'h99); rd_chk(BASE + 7, "R8");
      // R7 weekday / century
      wr(BASE + 4, 8'hC5); rd_chk(BASE + 4, "R7");
      chk("R7", rdata, 8'h45, "day register");

      // R4 stop and resume
      wr(BASE + 1, 8'h90); tick_n(3); rd_chk(BASE + 1, "R4");
      chk("R4", rdata, 8'h90, "stopped seconds");
      wr(BASE + 1, 8'h10); tick_n(1); rd_chk(BASE + 1, "R4");
      chk("R4", rdata, 8'h11, "resumed seconds");

      // R10/R11 full rollover at end of year 99
      wr(BASE + 4, 8'h07);
      set_time(99, 12, 31, 23, 59, 59);
      tick_n(1);
      for (int r = 1; r < 8; r++) rd_chk(BASE + r, "R11");
      rd_chk(BASE + 4, "R10");
      chk("R10", rdata, 8'h01, "weekday wrap");
      // leap February
      set_time(24, 2, 28, 23, 59, 59); tick_n(1); rd_chk(BASE + 5, "R11");
      chk("R11", rdata, 8'h29, "leap Feb 29");
      set_time(23, 2, 28, 23, 59, 59); tick_n(1); rd_chk(BASE + 6, "R11");
      chk("R11", rdata, 8'h03, "non-leap to March");
      set_time(10, 4, 30, 23, 59, 59); tick_n(1); rd_chk(BASE + 5, "R11");

      // R12 tick with window write is dropped
      wr(BASE + 1, 8'h20);
      wr(BASE + 7, 8'h50, 1);
      rd_chk(BASE + 1, "R12");
      chk("R12", rdata, 8'h20, "seconds after colliding tick");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 2) begin
            wr(int'($urandom_range(0, BASE - 1)), 8'($urandom));
         end else if (op < 4) begin
            int a;
            a = int'($urandom_range(0, BASE - 1));
            if (ram_v[a]) rd_chk(a, "R1");
         end else if (op < 6) begin
            int r;
            r = int'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) wr(BASE + r, 8'($urandom));
            else wr(BASE + r, enc(int'($urandom_range(0, 99))) | 8'($urandom_range(0, 1) << 7));
         end else if (op < 8) begin
            tick_n(int'($urandom_range(1, 5)));
         end else begin
            rd_chk(BASE + int'($urandom_range(0, 7)), "R2");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule